// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an asynchronous static RAM of 24-bit words. The RAM has three chip enables: two are active low and one is active high. The host issues one word at a time over a valid/ready handshake that carries an address, write data and a write flag. The controller turns each request into a correctly timed sequence of strobes on the memory pins. After a read, it returns the word on a single-cycle response pulse.

Each phase length is a cycle count, computed at elaboration time from a clock-period parameter and the memory's nanosecond minima. The count is the ceiling of the nanoseconds divided by the period, and never less than one cycle. The shared data bus is split into an outgoing word, an incoming word and a driver enable, so a pad ring can build the tristate. Output enable stays high for the whole write strobe, so the shorter write-pulse minimum applies.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and directly after it, req_ready is 1 and rsp_valid is 0. All three enables are inactive (mem_sel_a_n=1, mem_sel_b_n=1, mem_sel_c=0), mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R2: req_ready is high only while the controller is idle. A request is taken on a rising edge with req_valid and req_ready both high. req_ready is low from the next cycle until the operation has finished.
- R3: A read selects the memory (mem_sel_a_n=0, mem_sel_b_n=0, mem_sel_c=1) with mem_we_n=1 and mem_oe_n=0. This lasts for exactly RD_CYC = max(1, ceil(T_RC_NS/CLK_NS)) consecutive cycles, starting the cycle after acceptance, with mem_dq_oe low throughout.
- R4: mem_dq_in is sampled at the end of the last read cycle. rsp_valid is then high for exactly one cycle, with rsp_rdata equal to the sampled word.
- R5: A write selects the memory with mem_we_n=0, mem_oe_n=1, mem_dq_oe=1 and mem_dq_out equal to the accepted write data. This lasts for exactly WR_CYC = max(1, ceil(max(T_PWE_NS, T_AW_NS, T_SD_NS)/CLK_NS)) consecutive cycles.
- R6: The write strobe is followed by exactly one hold cycle. In that cycle mem_we_n=1 and all enables are inactive, while mem_dq_oe stays 1 and address and data are unchanged. In the cycle after it, the controller is idle with mem_dq_oe=0.
- R7: mem_addr equals the accepted address from the first cycle after acceptance until the controller is idle again, including the hold cycle.
- R8: A write accepted directly after a completed read gets one turnaround cycle before its strobe. In that cycle the memory is deselected, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. A write following a write, or the first access after reset, starts its strobe in the cycle right after acceptance.
- R9: The controller never drives the bus while the memory may drive it: mem_dq_oe=1 implies mem_oe_n=1. When idle, all three enables are inactive and mem_we_n=1.
- R10: Write data is captured at acceptance. Changes on req_wdata after the accepting edge have no effect on the word stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (24) | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | DATA_W (24) | Read data |
| mem_addr | output | ADDR_W (17) | Memory address |
| mem_sel_a_n | output | 1 | First enable, active low |
| mem_sel_b_n | output | 1 | Second enable, active low |
| mem_sel_c | output | 1 | Third enable, active high |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DATA_W (24) | Word driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | DATA_W (24) | Word returned by the memory |

## Verification
The checker watches rules that hold on every cycle:
- no bus contention between the two drivers;
- enables and write enable idle whenever the controller is ready;
- write enable only with output enable high and the memory selected;
- a hold cycle with drivers still on after every strobe;
- a stable address while busy;
- single-cycle response pulses.

Only the bench scenarios can show the rest:
- exact phase lengths, compared against counts the bench derives from nanoseconds;
- the turnaround cycle appearing only after a read;
- the data actually landing in and coming back from every location of a small memory model. That model supplies valid read data only in the last read cycle and rejects strobes that are too short.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 24,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 10,
  parameter int T_PWE_NS = 8,
  parameter int T_AW_NS  = 8,
  parameter int T_SD_NS  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_a_n,
  output logic              mem_sel_b_n,
  output logic              mem_sel_c,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WR_NS_A = (T_PWE_NS > T_AW_NS) ? T_PWE_NS : T_AW_NS;
  localparam int WR_NS   = (WR_NS_A > T_SD_NS) ? WR_NS_A : T_SD_NS;
  localparam int RD_CYC  = to_cyc(T_RC_NS);
  localparam int WR_CYC  = to_cyc(WR_NS);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_STRB, S_HOLD} state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last_rd;
  logic              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      last_rd   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          cnt     <= '0;
          if (!req_write)   st <= S_READ;
          else if (last_rd) st <= S_TURN;
          else              st <= S_STRB;
        end
        S_READ: if (cnt == RD_LAST) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          last_rd   <= 1'b1;
          st        <= S_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_TURN: begin
          cnt <= '0;
          st  <= S_STRB;
        end
        S_STRB: begin
          last_rd <= 1'b0;
          if (cnt == WR_LAST) st <= S_HOLD;
          else                cnt <= cnt + 1'b1;
        end
        S_HOLD:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel         = (st == S_READ) || (st == S_STRB);
  assign req_ready   = (st == S_IDLE);
  assign mem_sel_a_n = !sel;
  assign mem_sel_b_n = !sel;
  assign mem_sel_c   = sel;
  assign mem_oe_n    = (st != S_READ);
  assign mem_we_n    = (st != S_STRB);
  assign mem_dq_oe   = (st == S_STRB) || (st == S_HOLD);
  assign mem_dq_out  = wdata_q;
  assign mem_addr    = addr_q;

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_a_n,
  input logic              mem_sel_b_n,
  input logic              mem_sel_c,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic on, off;
  assign on  = !mem_sel_a_n && !mem_sel_b_n && mem_sel_c;
  assign off = mem_sel_a_n && mem_sel_b_n && !mem_sel_c;

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !rsp_valid && off && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  p_read_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (on && mem_we_n && !mem_dq_oe));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_strobe_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && on && mem_dq_oe));

  p_hold_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && off && $stable(mem_addr)));

  p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && $past(!req_ready) |-> $stable(mem_addr));

  p_drive_after_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_idle_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (off && mem_we_n && mem_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_sel_a_n(mem_sel_a_n),
  .mem_sel_b_n(mem_sel_b_n), .mem_sel_c(mem_sel_c), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_test.sv
module sram_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 24;
  localparam int CNS = 4;
  localparam int RD_CYC_E = (10 + CNS - 1) / CNS;
  localparam int WR_CYC_E = (8 + CNS - 1) / CNS;
  localparam int WORDS = 1 << AW;
  localparam logic [DW-1:0] JUNK = 24'hA5C3E1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_sel_a_n, mem_sel_b_n, mem_sel_c, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int n_run = 0, n_fail = 0, m_run = 0, m_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CNS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_a_n(mem_sel_a_n), .mem_sel_b_n(mem_sel_b_n), .mem_sel_c(mem_sel_c),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic [DW-1:0] mem [WORDS];
  logic sel_on, sel_off, rd_c, wr_c;
  int rd_age = 0, w_age = 0;
  logic w_act = 1'b0;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;

  assign sel_on  = !mem_sel_a_n && !mem_sel_b_n && mem_sel_c;
  assign sel_off = mem_sel_a_n && mem_sel_b_n && !mem_sel_c;
  assign rd_c = sel_on && mem_we_n && !mem_oe_n;
  assign wr_c = sel_on && !mem_we_n;
  assign mem_dq_in = (rd_c && rd_age >= RD_CYC_E - 1) ? mem[mem_addr] : JUNK;

  always @(posedge clk) begin
    rd_age <= rd_c ? rd_age + 1 : 0;
    if (mem_dq_oe && rd_c) begin
      m_fail++;
      $display("FAIL R9: bus contention, got dq_oe=1 expected 0 while memory drives");
    end
    if (wr_c) begin
      if (w_act && mem_addr != w_addr) begin
        m_fail++;
        $display("FAIL R7: address moved in strobe, got %0h expected %0h", mem_addr, w_addr);
      end
      w_act <= 1'b1; w_age <= w_age + 1; w_addr <= mem_addr; w_data <= mem_dq_out;
    end else if (w_act) begin
      m_run++;
      if (w_age >= WR_CYC_E) mem[w_addr] <= w_data;
      else begin
        m_fail++;
        $display("FAIL R5: write strobe too short, got %0d expected %0d", w_age, WR_CYC_E);
      end
      w_act <= 1'b0; w_age <= 0;
    end
  end

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 24'h0B3D1 + salt * 24'h31F) ^ 24'h5A5A5A);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input bit after_rd);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d;  // R10: late change must be ignored
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
    if (after_rd) begin
      chk(sel_off && mem_oe_n && mem_we_n && !mem_dq_oe, "R8 turnaround", {sel_off, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
      @(negedge clk);
    end
    chk(!mem_we_n, "R8 strobe start", mem_we_n, 0);
    n = 0;
    while (!mem_we_n && n < 20) begin
      chk(sel_on && mem_oe_n && mem_dq_oe && mem_dq_out == d, "R5 strobe pins", mem_dq_out, d);
      chk(mem_addr == AW'(a), "R7 addr in strobe", mem_addr, a);
      n++;
      @(negedge clk);
    end
    chk(n == WR_CYC_E, "R5 strobe length", n, WR_CYC_E);
    chk(sel_off && mem_dq_oe && mem_dq_out == d, "R6 hold cycle", {sel_off, mem_dq_oe}, 2'b11);
    chk(mem_addr == AW'(a), "R7 addr in hold", mem_addr, a);
    @(negedge clk);
    chk(req_ready && !mem_dq_oe, "R6 release", {req_ready, mem_dq_oe}, 2'b10);
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] e);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 busy after accept", req_ready, 0);
    n = 0;
    while (rd_c && n < 20) begin
      chk(!mem_dq_oe && mem_addr == AW'(a), "R3 read pins", mem_addr, a);
      chk(!rsp_valid, "R4 no early response", rsp_valid, 0);
      n++;
      @(negedge clk);
    end
    chk(n == RD_CYC_E, "R3 read length", n, RD_CYC_E);
    chk(rsp_valid, "R4 response strobe", rsp_valid, 1);
    chk(rsp_rdata == e, "R4 read data", rsp_rdata, e);
    @(negedge clk);
    chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + m_run + 1, n_fail + m_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && sel_off && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 in reset", {req_ready, rsp_valid, sel_off, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b101110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && sel_off && !mem_dq_oe, "R1 after reset", {req_ready, sel_off, mem_dq_oe}, 3'b110);

    for (int a = 0; a < WORDS; a++) do_write(a, pat(a, 0), 1'b0);
    for (int a = 0; a < WORDS; a++) do_read(a, pat(a, 0));
    // read then write: turnaround (R8), then write after write without one
    for (int a = 0; a < WORDS; a += 5) begin
      do_read(a, pat(a, 0));
      do_write(a, pat(a, 1), 1'b1);
      do_write((a + 1) % WORDS, pat(a + 1, 1), 1'b0);
      do_read(a, pat(a, 1));
      do_read((a + 1) % WORDS, pat(a + 1, 1));
    end
    // R10: stored words reflect data at acceptance, not the later inverted value
    do_write(WORDS - 1, 24'h000000, 1'b1);
    do_write(0, 24'hFFFFFF, 1'b0);
    do_read(WORDS - 1, 24'h000000);
    do_read(0, 24'hFFFFFF);

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run + m_run, n_fail + m_fail);
    $finish;
  end
endmodule